// File: doc/BRIEF.md
# Multi-block erase scheduler

This block sits behind the command decoder of a NOR-style flash controller model and owns every multi-block erase. The decoder hands it one block address per accepted selection strobe. The scheduler gathers these addresses into a pending bitmap. The collection phase ends when a quiet period of `SEL_WIN` clock cycles passes with no new selection, and each new selection starts that period again. After that the scheduler erases the pending blocks one at a time, lowest address first. Blocks flagged in the protect bitmap are passed over.

The scheduler does not model the erase itself. A per-block counter stands in for the cell erase time. When a block finishes, the scheduler emits a single-cycle completion strobe that carries the block address. It supports three controls. Suspend works both in the collection phase and during erasure. Resume is accepted only while the controller reports read-array mode. Reset aborts a collection phase but has no effect while suspended. Three flags feed a status register: busy, erase-timer (status bit DQ3) and suspended.

Selection uses a valid/ready handshake. `sel_ready` is high only in the idle and collection phases. The selection transfers on a cycle where both `sel_valid` and `sel_ready` are high. A strobe offered while `sel_ready` is low is dropped, not stored: the block has no buffer at its edge. The completion strobe has no ready signal. It is a one-cycle pulse that the consumer must take.

Top module: `erase_sched`

## Requirements
- R1: After reset, busy, erase_tmr, suspended and done_valid are 0 and sel_ready is 1.
- R2: erase_tmr stays 0 for SEL_WIN-1 cycles after the last accepted selection and rises in the cycle after that. Each accepted selection restarts this count.
- R3: While sel_ready is 0, a strobe on sel_valid is ignored, and its block is never erased by the current or any later operation.
- R4: Each pending block with protect[i]=0 is erased once, in ascending index order (bit i of the bitmaps stands for block address i). Each erase takes one scan cycle plus ERASE_CYC cycles and ends with one done_valid pulse carrying the address on done_blk. With n such blocks, erase_tmr is high for n*(ERASE_CYC+1)+1 cycles.
- R5: If every pending block is protected, there is no done_valid pulse. busy and erase_tmr stay high for PROT_CYC+1 cycles, then the block returns to idle.
- R6: A suspend during the collection phase takes effect in the next cycle (suspended=1, busy=0, erase_tmr=0). A valid resume then starts erasure in the next cycle, and sel_ready stays 0 from then on.
- R7: A suspend during erasure raises suspended exactly SUSP_LAT cycles after the request is sampled. Erase progress is held, no done_valid is produced while suspended, and erase_tmr stays 1.
- R8: Resume is taken only when read_array=1; otherwise the block stays suspended. Suspend and resume can be repeated, and every pending block is still erased exactly once.
- R9: A reset_req during the collection phase keeps busy=1 with erase_tmr=0 for ABORT_CYC cycles, then returns to idle with the pending set cleared and no erase. A reset_req while suspended has no effect.
- R10: erase_tmr is 0 whenever sel_ready is 1 and in both the suspended and abort phases of the collection window. It is 1 from the start of erasure until the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Selection strobe valid |
| sel_ready | output | 1 | Selection can be accepted |
| sel_addr | input | AW | Block address of the selection |
| protect | input | NUM_BLK | Per-block protect bitmap, 1 = protected |
| suspend_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| reset_req | input | 1 | Read/reset command pulse |
| read_array | input | 1 | Controller is in read-array mode |
| busy | output | 1 | Collection, abort, scan or erase activity |
| erase_tmr | output | 1 | Erase-timer status flag (DQ3) |
| suspended | output | 1 | Operation paused |
| done_valid | output | 1 | One-cycle pulse: a block finished erasing |
| done_blk | output | AW | Address of the finished block |

## Verification
The assertions assume that the protect bitmap does not change while an operation is between its first selection and its return to idle. Under that assumption, a completion reported for a protected block is always a design fault. They also assume that all control pulses are synchronous to clk. The stimulus sets the protect pattern before the first selection of each operation and holds it until all three flags read zero. Every control pulse is driven on the falling edge, held for exactly one rising edge, and then withdrawn.

// File: rtl/esch_pkg.sv
package esch_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // nothing pending
    S_WIN,    // collecting selections
    S_WSUSP,  // suspended before erase start
    S_ABORT,  // reset during collection, draining
    S_PICK,   // scan bitmap for next block
    S_ERASE,  // cell counter running
    S_SLAT,   // suspend latency
    S_SUSP,   // suspended mid-erase
    S_PROT    // all selected blocks protected
  } esch_st_e;
endpackage

// File: rtl/esch_pick.sv
module esch_pick #(
  parameter int N  = 128,
  parameter int AW = 7
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [AW-1:0] idx
);
  // Lowest set bit wins: scanning downward lets the last hit stand.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
  end
endmodule

// File: rtl/esch_tick.sv
module esch_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] lim,
  output logic          hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end

  assign hit = en && !clr && (cnt == lim);
endmodule

// File: rtl/erase_sched.sv
module erase_sched
  import esch_pkg::*;
#(
  parameter int NUM_BLK   = 128,
  parameter int SEL_WIN   = 10000,
  parameter int ERASE_CYC = 100000,
  parameter int PROT_CYC  = 20000,
  parameter int SUSP_LAT  = 4000,
  parameter int ABORT_CYC = 2000,
  localparam int AW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_valid,
  output logic               sel_ready,
  input  logic [AW-1:0]      sel_addr,
  input  logic [NUM_BLK-1:0] protect,
  input  logic               suspend_req,
  input  logic               resume_req,
  input  logic               reset_req,
  input  logic               read_array,
  output logic               busy,
  output logic               erase_tmr,
  output logic               suspended,
  output logic               done_valid,
  output logic [AW-1:0]      done_blk
);
  localparam int T1   = (SEL_WIN > ABORT_CYC) ? SEL_WIN : ABORT_CYC;
  localparam int T2   = (T1 > PROT_CYC) ? T1 : PROT_CYC;
  localparam int T3   = (T2 > SUSP_LAT) ? T2 : SUSP_LAT;
  localparam int TMAX = (T3 > ERASE_CYC) ? T3 : ERASE_CYC;
  localparam int CW   = $clog2(TMAX + 1);

  esch_st_e           st, nx;
  logic [NUM_BLK-1:0] pend;
  logic [AW-1:0]      blk;
  logic               did_erase;

  logic               acc;
  logic               found;
  logic [AW-1:0]      idx;
  logic               clr_p, en_p, p_hit;
  logic [CW-1:0]      lim_p;
  logic               clr_c, en_c, c_hit, c_done;

  assign sel_ready = (st == S_IDLE) || (st == S_WIN);
  assign acc       = sel_valid && sel_ready;

  esch_pick #(.N(NUM_BLK), .AW(AW)) u_pick (
    .vec   (pend & ~protect),
    .found (found),
    .idx   (idx)
  );

  // Shared phase counter: window, abort drain, protect wait, suspend latency.
  esch_tick #(.CW(CW)) u_phase (
    .clk (clk), .rst_n (rst_n), .clr (clr_p), .en (en_p),
    .lim (lim_p), .hit (p_hit)
  );

  // Cell busy model: kept while suspended, cleared per block.
  esch_tick #(.CW(CW)) u_cell (
    .clk (clk), .rst_n (rst_n), .clr (clr_c), .en (en_c),
    .lim (CW'(ERASE_CYC - 1)), .hit (c_hit)
  );

  always_comb begin
    unique case (st)
      S_WIN:   lim_p = CW'(SEL_WIN - 1);
      S_ABORT: lim_p = CW'(ABORT_CYC - 1);
      S_SLAT:  lim_p = CW'(SUSP_LAT - 1);
      default: lim_p = CW'(PROT_CYC - 1);
    endcase
  end

  assign en_p   = (st == S_WIN) || (st == S_ABORT) || (st == S_SLAT) || (st == S_PROT);
  assign en_c   = (st == S_ERASE) && !suspend_req;
  assign clr_c  = (st == S_PICK);
  assign c_done = en_c && c_hit;

  always_comb begin
    nx    = st;
    clr_p = 1'b0;
    unique case (st)
      S_IDLE: if (acc) begin nx = S_WIN; clr_p = 1'b1; end
      S_WIN: begin
        if (reset_req)        begin nx = S_ABORT; clr_p = 1'b1; end
        else if (suspend_req) nx = S_WSUSP;
        else if (acc)         clr_p = 1'b1;
        else if (p_hit)       nx = S_PICK;
      end
      S_WSUSP: if (resume_req && read_array) nx = S_PICK;
      S_ABORT: if (p_hit) nx = S_IDLE;
      S_PICK: begin
        if (found)          nx = S_ERASE;
        else if (did_erase) nx = S_IDLE;
        else begin nx = S_PROT; clr_p = 1'b1; end
      end
      S_ERASE: begin
        if (suspend_req) begin nx = S_SLAT; clr_p = 1'b1; end
        else if (c_hit)  nx = S_PICK;
      end
      S_SLAT:  if (p_hit) nx = S_SUSP;
      S_SUSP:  if (resume_req && read_array) nx = S_ERASE;
      S_PROT:  if (p_hit) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pend       <= '0;
      blk        <= '0;
      did_erase  <= 1'b0;
      done_valid <= 1'b0;
      done_blk   <= '0;
    end else begin
      st         <= nx;
      done_valid <= c_done;
      if (acc) pend[sel_addr] <= 1'b1;
      if (c_done) begin
        done_blk   <= blk;
        pend[blk]  <= 1'b0;
        did_erase  <= 1'b1;
      end
      if (st == S_PICK && found) blk <= idx;
      if (nx == S_IDLE) begin
        pend      <= '0;
        did_erase <= 1'b0;
      end
    end
  end

  assign busy      = (st == S_WIN) || (st == S_ABORT) || (st == S_PICK) ||
                     (st == S_ERASE) || (st == S_SLAT) || (st == S_PROT);
  assign erase_tmr = (st == S_PICK) || (st == S_ERASE) || (st == S_SLAT) ||
                     (st == S_SUSP) || (st == S_PROT);
  assign suspended = (st == S_WSUSP) || (st == S_SUSP);
endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk #(
  parameter int NUM_BLK = 128,
  parameter int AW      = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel_valid,
  input logic               sel_ready,
  input logic [NUM_BLK-1:0] protect,
  input logic               resume_req,
  input logic               reset_req,
  input logic               read_array,
  input logic               busy,
  input logic               erase_tmr,
  input logic               suspended,
  input logic               done_valid,
  input logic [AW-1:0]      done_blk
);
  p_ready_no_timer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ready |-> !erase_tmr);

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_ready) |=> !erase_tmr);

  p_done_unprot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !protect[done_blk]);

  p_done_after_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(erase_tmr));

  p_susp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!busy && !done_valid));

  p_hold_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !(resume_req && read_array)) |=> suspended);

  p_resume_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !erase_tmr && resume_req && read_array) |=> (erase_tmr && !sel_ready));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_ready && reset_req) |=> (busy && !sel_ready && !erase_tmr));
endmodule

bind erase_sched erase_sched_chk #(.NUM_BLK(NUM_BLK), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_valid  (sel_valid),
  .sel_ready  (sel_ready),
  .protect    (protect),
  .resume_req (resume_req),
  .reset_req  (reset_req),
  .read_array (read_array),
  .busy       (busy),
  .erase_tmr  (erase_tmr),
  .suspended  (suspended),
  .done_valid (done_valid),
  .done_blk   (done_blk)
);

// File: tb/test_erase_sched.sv
`timescale 1ns/1ps
module test_erase_sched;
  localparam int N   = 8;
  localparam int AW  = 3;
  localparam int WIN = 6;
  localparam int ERC = 5;
  localparam int PRC = 7;
  localparam int SLT = 3;
  localparam int ABC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_valid = 1'b0;
  logic          sel_ready;
  logic [AW-1:0] sel_addr = '0;
  logic [N-1:0]  protect = '0;
  logic          suspend_req = 1'b0, resume_req = 1'b0, reset_req = 1'b0;
  logic          read_array = 1'b1;
  logic          busy, erase_tmr, suspended, done_valid;
  logic [AW-1:0] done_blk;

  int total = 0, fails = 0;
  int dlog[32];
  int dn = 0, ecnt = 0;

  always #2.5 clk = ~clk;

  erase_sched #(.NUM_BLK(N), .SEL_WIN(WIN), .ERASE_CYC(ERC), .PROT_CYC(PRC),
                .SUSP_LAT(SLT), .ABORT_CYC(ABC)) i_erase_sched (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_ready(sel_ready),
    .sel_addr(sel_addr), .protect(protect), .suspend_req(suspend_req),
    .resume_req(resume_req), .reset_req(reset_req), .read_array(read_array),
    .busy(busy), .erase_tmr(erase_tmr), .suspended(suspended),
    .done_valid(done_valid), .done_blk(done_blk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (done_valid && dn < 32) begin dlog[dn] = int'(done_blk); dn++; end
    if (erase_tmr) ecnt++;
  endtask

  task automatic clear_log();
    dn = 0; ecnt = 0;
  endtask

  task automatic sel_blk(input int a);
    sel_valid = 1'b1; sel_addr = AW'(a);
    tick();
    sel_valid = 1'b0;
  endtask

  task automatic run_wait();
    for (int k = 0; k < 600; k++) begin
      if (!busy && !suspended && !erase_tmr) break;
      tick();
    end
  endtask

  task automatic expect_list(input logic [N-1:0] m, input string req);
    int k = 0;
    bit ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        if (k >= dn || dlog[k] != i) ok = 1'b0;
        k++;
      end
    end
    chk(dn == k, req, dn, k);
    chk(ok, req, ok, 1);
  endtask

  // Issue a suspend in the erase phase and check its latency and quiet period.
  task automatic susp_in_erase();
    suspend_req = 1'b1;
    tick();
    suspend_req = 1'b0;
    for (int k = 0; k < SLT - 1; k++) tick();
    chk(!suspended && busy, "R7", suspended, 0);
    tick();
    chk(suspended && !busy && erase_tmr, "R7", suspended, 1);
    begin
      int d0 = dn;
      reset_req = 1'b1; tick(); reset_req = 1'b0;
      read_array = 1'b0; resume_req = 1'b1; tick(); resume_req = 1'b0; read_array = 1'b1;
      for (int k = 0; k < 4; k++) tick();
      chk(suspended && dn == d0, "R8", suspended, 1);
      chk(dn == d0, "R9", dn, d0);
    end
    resume_req = 1'b1; tick(); resume_req = 1'b0;
    chk(!suspended && busy, "R8", suspended, 0);
  endtask

  initial begin
    #(150000 * 5);
    fails++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !erase_tmr && !suspended && !done_valid && sel_ready, "R1", busy, 0);

    // R2 restart of the window
    clear_log();
    sel_blk(3);
    for (int k = 0; k < WIN - 2; k++) tick();
    sel_blk(5);
    for (int k = 0; k < WIN - 1; k++) tick();
    chk(!erase_tmr, "R2", erase_tmr, 0);
    tick();
    chk(erase_tmr, "R2", erase_tmr, 1);
    // R3 selection offered while not ready
    tick();
    chk(!sel_ready, "R3", sel_ready, 0);
    sel_valid = 1'b1; sel_addr = 3'd1;
    tick(); tick();
    sel_valid = 1'b0;
    run_wait();
    expect_list(8'b0010_1000, "R3");

    // R6 suspend during window, R8 resume gating, R9 reset ignored
    clear_log();
    sel_blk(6); sel_blk(4);
    suspend_req = 1'b1; tick(); suspend_req = 1'b0;
    chk(suspended && !busy && !erase_tmr, "R6", suspended, 1);
    chk(!sel_ready, "R6", sel_ready, 0);
    reset_req = 1'b1; tick(); reset_req = 1'b0;
    chk(suspended, "R9", suspended, 1);
    read_array = 1'b0; resume_req = 1'b1; tick(); resume_req = 1'b0; read_array = 1'b1;
    chk(suspended && !erase_tmr, "R8", suspended, 1);
    resume_req = 1'b1; tick(); resume_req = 1'b0;
    chk(erase_tmr && !suspended, "R6", erase_tmr, 1);
    sel_valid = 1'b1; sel_addr = 3'd0; tick(); sel_valid = 1'b0;
    run_wait();
    expect_list(8'b0101_0000, "R6");

    // R7 suspend during erase, repeated twice (R8)
    clear_log();
    sel_blk(3); sel_blk(1);
    for (int k = 0; k < WIN; k++) tick();
    tick();
    susp_in_erase();
    for (int k = 0; k < 40; k++) begin
      if (done_valid) break;
      tick();
    end
    tick();
    susp_in_erase();
    run_wait();
    expect_list(8'b0000_1010, "R8");

    // R9 abort in window
    clear_log();
    sel_blk(5);
    tick();
    reset_req = 1'b1; tick(); reset_req = 1'b0;
    for (int k = 0; k < ABC - 1; k++) begin
      chk(busy && !erase_tmr, "R9", busy, 1);
      tick();
    end
    chk(busy, "R9", busy, 1);
    tick();
    chk(!busy && !erase_tmr && sel_ready, "R9", busy, 0);
    sel_blk(2);
    run_wait();
    expect_list(8'b0000_0100, "R9");

    // Sweep: every selection set against three protect patterns
    for (int s = 1; s < (1 << N); s++) begin
      for (int pat = 0; pat < 3; pat++) begin
        logic [N-1:0] sv, pv, ev;
        int n;
        sv = N'(s);
        pv = (pat == 0) ? '0 : (pat == 1) ? 8'h5A : sv;
        ev = sv & ~pv;
        n  = $countones(ev);
        protect = pv;
        clear_log();
        for (int i = N - 1; i >= 0; i--) if (sv[i]) sel_blk(i);
        for (int k = 0; k < WIN - 1; k++) tick();
        chk(!erase_tmr && busy, "R10", erase_tmr, 0);
        tick();
        chk(erase_tmr, "R2", erase_tmr, 1);
        ecnt = 1;
        run_wait();
        if (n == 0) begin
          chk(dn == 0, "R5", dn, 0);
          chk(ecnt == PRC + 1, "R5", ecnt, PRC + 1);
        end else begin
          expect_list(ev, "R4");
          chk(ecnt == n * (ERC + 1) + 1, "R4", ecnt, n * (ERC + 1) + 1);
        end
        protect = '0;
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule